// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block sits behind the bit-level front end of an I2C target and decides, one received byte at a time, whether the address phase that follows a start or repeated start selects this target. It works with either a 7-bit or a 10-bit own address, chosen by a mode input. For every address-phase byte it gives a one-cycle decision pulse with an acknowledge bit. It also holds flags for the selected state and the transfer direction.

It also handles the general call. With the general-call enable set, the all-zero write address is acknowledged and the next byte is classified. A set least significant bit marks a hardware general call from a master that reports its own 7-bit address. The value 0x00 is an illegal code and is flagged. Two fixed command codes are reported, and every other code is ignored. After a complete 10-bit write selection, a repeated start followed by the 10-bit prefix with the read bit reselects the target without a second address byte.

Top module: `i2c_tgt_addr_rx`

## Requirements
- R1: The decision (`dec_vld_o`, `ack_o`) and the flags change in the cycle after the clock edge that samples `byte_vld_i`. In 7-bit mode, a first byte whose bits [7:1] equal `own_addr_i[6:0]` is acknowledged, sets `addressed_o`, and sets `read_o` to bit 0 of that byte. A different 7-bit address gives `dec_vld_o`=1 with `ack_o`=0.
- R2: A first byte whose bits [7:3] are 11111 is never acknowledged and never sets `addressed_o`, in either mode. In 7-bit mode, no first byte whose bits [7:4] are 1111 matches.
- R3: In 10-bit mode, the first byte 11110 followed by `own_addr_i[9:8]` and a 0 bit is acknowledged without setting `addressed_o`. The following byte is acknowledged, and sets `addressed_o` with `read_o`=0, only when it equals `own_addr_i[7:0]`. Otherwise it is not acknowledged.
- R4: A 10-bit prefix whose two address bits differ from `own_addr_i[9:8]` is not acknowledged. In 7-bit mode, a 10-bit prefix byte is not acknowledged, and the byte after it produces no decision, even when that byte equals the target's 7-bit address.
- R5: After a full 10-bit write selection, a repeated start followed by the prefix with bit 0 = 1 is acknowledged and sets `addressed_o` and `read_o`. Without that earlier selection, the same byte is not acknowledged.
- R6: A first byte of 0x00 is acknowledged and sets `gcall_o` only while `gc_en_i` is 1. With `gc_en_i`=0 it gives `dec_vld_o`=1 and `ack_o`=0.
- R7: After an acknowledged general call, a second byte with bit 0 = 1 is acknowledged, sets `hw_gcall_o`, and places its bits [7:1] on `hw_master_o`.
- R8: A second general-call byte of 0x00 is not acknowledged and sets `gc_illegal_o`.
- R9: A second general-call byte of 0x06 is acknowledged with `gc_cmd_o`=1, and 0x04 is acknowledged with `gc_cmd_o`=2. Any other even code gives `dec_vld_o`=1, `ack_o`=0, and leaves `gc_cmd_o`, `gc_illegal_o` and `hw_gcall_o` at 0.
- R10: A stop clears every flag and the 10-bit reselection memory, and bytes that arrive after a stop produce no decision. A start clears the flags.
- R11: Bytes that arrive after the address phase produce no decision and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or repeated-start strobe |
| stop_i | input | 1 | Stop strobe |
| byte_vld_i | input | 1 | Received-byte strobe |
| byte_i | input | 8 | Received byte |
| own_addr_i | input | 10 | Own address (the low 7 bits are used in 7-bit mode) |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| gc_en_i | input | 1 | General-call enable |
| dec_vld_o | output | 1 | Pulse: an address-phase byte was decided |
| ack_o | output | 1 | Acknowledge for the decided byte |
| addressed_o | output | 1 | This target is selected |
| read_o | output | 1 | Selected transfer is a read |
| gcall_o | output | 1 | A general call was accepted |
| hw_gcall_o | output | 1 | The general call is a hardware general call |
| hw_master_o | output | 7 | Address reported by the hardware master |
| gc_illegal_o | output | 1 | An illegal 0x00 second general-call byte was seen |
| gc_cmd_o | output | 2 | General-call command: 0 none, 1 code 0x06, 2 code 0x04 |

## Verification
The hardest situation to reach is the 10-bit read reselection. It depends on memory that must survive a repeated start but not a stop. The stimulus therefore first completes a 10-bit write selection, then issues a repeated start with the read prefix. It then repeats the same read prefix after a stop, where the prefix must be refused. A second hard point is a 7-bit target that sees a 10-bit prefix followed by a byte equal to its own address. The bench sends exactly that pair to show that the second byte is not decided.

// File: rtl/i2c_tgt_addr_pkg.sv
package i2c_tgt_addr_pkg;
  localparam int BYTE_W   = 8;
  localparam int A7_W     = 7;
  localparam int A10_W    = 10;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;
  localparam logic [4:0] RSVD_PREFIX = 5'b11111;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRST, ST_TEN_LO, ST_GC_2ND, ST_DATA
  } seq_state_t;

  typedef enum logic [2:0] {
    FK_NONE, FK_GC, FK_SEVEN_HIT, FK_TEN_W_HIT, FK_TEN_R_HIT
  } first_kind_t;

  typedef enum logic [2:0] {
    GK_NONE, GK_HW, GK_ILLEGAL, GK_CMD_RST, GK_CMD_LATCH
  } gc_kind_t;

  localparam logic [1:0] CMD_NONE  = 2'd0;
  localparam logic [1:0] CMD_RST   = 2'd1;
  localparam logic [1:0] CMD_LATCH = 2'd2;
endpackage

// File: rtl/i2c_first_byte_class.sv
module i2c_first_byte_class
  import i2c_tgt_addr_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [A10_W-1:0]  own_addr_i,
  input  logic              ten_bit_i,
  output first_kind_t       kind_o
);
  logic [A7_W-1:0] hdr;
  logic            rw;
  logic            is_ten_pfx;
  logic            is_1111;

  assign hdr        = byte_i[BYTE_W-1:1];
  assign rw         = byte_i[0];
  assign is_ten_pfx = (byte_i[7:3] == TEN_PREFIX);
  assign is_1111    = (byte_i[7:4] == 4'b1111);

  always_comb begin
    kind_o = FK_NONE;
    if (byte_i == '0) begin
      kind_o = FK_GC;
    end else if (ten_bit_i) begin
      if (is_ten_pfx && (byte_i[2:1] == own_addr_i[9:8])) begin
        kind_o = rw ? FK_TEN_R_HIT : FK_TEN_W_HIT;
      end
    end else if (!is_1111 && (hdr == own_addr_i[A7_W-1:0])) begin
      kind_o = FK_SEVEN_HIT;
    end
  end
endmodule

// File: rtl/i2c_gc_byte_class.sv
module i2c_gc_byte_class
  import i2c_tgt_addr_pkg::*;
#(
  parameter logic [7:0] CODE_RST   = 8'h06,
  parameter logic [7:0] CODE_LATCH = 8'h04
) (
  input  logic [BYTE_W-1:0] byte_i,
  output gc_kind_t          kind_o
);
  always_comb begin
    if (byte_i[0])                 kind_o = GK_HW;
    else if (byte_i == '0)         kind_o = GK_ILLEGAL;
    else if (byte_i == CODE_RST)   kind_o = GK_CMD_RST;
    else if (byte_i == CODE_LATCH) kind_o = GK_CMD_LATCH;
    else                           kind_o = GK_NONE;
  end
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_tgt_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [7:0]        own_lo_i,
  input  logic              gc_en_i,
  input  first_kind_t       first_kind_i,
  input  gc_kind_t          gc_kind_i,
  output logic              dec_vld_o,
  output logic              ack_o,
  output logic              addressed_o,
  output logic              read_o,
  output logic              gcall_o,
  output logic              hw_gcall_o,
  output logic [A7_W-1:0]   hw_master_o,
  output logic              gc_illegal_o,
  output logic [1:0]        gc_cmd_o
);
  seq_state_t      st_q, st_n;
  logic            ten_sel_q, ten_sel_n;
  logic            vld_n, ack_n, adr_n, rd_n, gc_n, hw_n, ill_n;
  logic [A7_W-1:0] mst_n;
  logic [1:0]      cmd_n;
  logic            upd_en;

  assign upd_en = start_i | stop_i | byte_vld_i;

  always_comb begin
    st_n = st_q; ten_sel_n = ten_sel_q;
    vld_n = 1'b0; ack_n = 1'b0;
    adr_n = addressed_o; rd_n = read_o; gc_n = gcall_o; hw_n = hw_gcall_o;
    ill_n = gc_illegal_o; mst_n = hw_master_o; cmd_n = gc_cmd_o;
    if (stop_i) begin
      st_n = ST_IDLE; ten_sel_n = 1'b0;
      adr_n = 1'b0; rd_n = 1'b0; gc_n = 1'b0; hw_n = 1'b0;
      ill_n = 1'b0; mst_n = '0; cmd_n = CMD_NONE;
    end else if (start_i) begin
      st_n = ST_FIRST;
      adr_n = 1'b0; rd_n = 1'b0; gc_n = 1'b0; hw_n = 1'b0;
      ill_n = 1'b0; mst_n = '0; cmd_n = CMD_NONE;
    end else if (byte_vld_i) begin
      unique case (st_q)
        ST_FIRST: begin
          vld_n = 1'b1; ten_sel_n = 1'b0; st_n = ST_DATA;
          unique case (first_kind_i)
            FK_GC: if (gc_en_i) begin
              ack_n = 1'b1; gc_n = 1'b1; st_n = ST_GC_2ND;
            end
            FK_SEVEN_HIT: begin
              ack_n = 1'b1; adr_n = 1'b1; rd_n = byte_i[0];
            end
            FK_TEN_W_HIT: begin
              ack_n = 1'b1; st_n = ST_TEN_LO;
            end
            FK_TEN_R_HIT: if (ten_sel_q) begin
              ack_n = 1'b1; adr_n = 1'b1; rd_n = 1'b1; ten_sel_n = 1'b1;
            end
            default: ;
          endcase
        end
        ST_TEN_LO: begin
          vld_n = 1'b1; st_n = ST_DATA;
          if (byte_i == own_lo_i) begin
            ack_n = 1'b1; adr_n = 1'b1; rd_n = 1'b0; ten_sel_n = 1'b1;
          end
        end
        ST_GC_2ND: begin
          vld_n = 1'b1; st_n = ST_DATA;
          unique case (gc_kind_i)
            GK_HW:        begin ack_n = 1'b1; hw_n = 1'b1; mst_n = byte_i[7:1]; end
            GK_ILLEGAL:   ill_n = 1'b1;
            GK_CMD_RST:   begin ack_n = 1'b1; cmd_n = CMD_RST; end
            GK_CMD_LATCH: begin ack_n = 1'b1; cmd_n = CMD_LATCH; end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld_o <= 1'b0;
      ack_o     <= 1'b0;
    end else begin
      dec_vld_o <= vld_n;
      ack_o     <= ack_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ten_sel_q <= 1'b0;
      addressed_o <= 1'b0; read_o <= 1'b0; gcall_o <= 1'b0; hw_gcall_o <= 1'b0;
      hw_master_o <= '0; gc_illegal_o <= 1'b0; gc_cmd_o <= CMD_NONE;
    end else if (upd_en) begin
      st_q <= st_n; ten_sel_q <= ten_sel_n;
      addressed_o <= adr_n; read_o <= rd_n; gcall_o <= gc_n; hw_gcall_o <= hw_n;
      hw_master_o <= mst_n; gc_illegal_o <= ill_n; gc_cmd_o <= cmd_n;
    end
  end

  AST_RSVD_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !start_i && !stop_i && st_q == ST_FIRST && byte_i[7:3] == RSVD_PREFIX)
      |=> (!ack_o && !addressed_o)); // R2
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!addressed_o && !gcall_o && !hw_gcall_o && !gc_illegal_o && gc_cmd_o == CMD_NONE)); // R10
  AST_ACK_HAS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> dec_vld_o); // R1
  AST_HW_NEEDS_GC: assert property (@(posedge clk) disable iff (!rst_n)
    hw_gcall_o |-> gcall_o); // R7
  AST_NO_DEC_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !start_i && !stop_i && (st_q == ST_DATA || st_q == ST_IDLE))
      |=> (!dec_vld_o && $stable(addressed_o))); // R11
  AST_GC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !start_i && !stop_i && st_q == ST_FIRST && !gc_en_i && byte_i == 8'h00)
      |=> !ack_o); // R6
endmodule

// File: rtl/i2c_tgt_addr_rx.sv
module i2c_tgt_addr_rx
  import i2c_tgt_addr_pkg::*;
#(
  parameter logic [7:0] GC_CODE_RST   = 8'h06,
  parameter logic [7:0] GC_CODE_LATCH = 8'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic [9:0] own_addr_i,
  input  logic       ten_bit_i,
  input  logic       gc_en_i,
  output logic       dec_vld_o,
  output logic       ack_o,
  output logic       addressed_o,
  output logic       read_o,
  output logic       gcall_o,
  output logic       hw_gcall_o,
  output logic [6:0] hw_master_o,
  output logic       gc_illegal_o,
  output logic [1:0] gc_cmd_o
);
  first_kind_t fkind;
  gc_kind_t    gkind;

  i2c_first_byte_class u_first (
    .byte_i(byte_i), .own_addr_i(own_addr_i), .ten_bit_i(ten_bit_i), .kind_o(fkind)
  );

  i2c_gc_byte_class #(.CODE_RST(GC_CODE_RST), .CODE_LATCH(GC_CODE_LATCH)) u_gc (
    .byte_i(byte_i), .kind_o(gkind)
  );

  i2c_addr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .own_lo_i(own_addr_i[7:0]),
    .gc_en_i(gc_en_i), .first_kind_i(fkind), .gc_kind_i(gkind),
    .dec_vld_o(dec_vld_o), .ack_o(ack_o), .addressed_o(addressed_o),
    .read_o(read_o), .gcall_o(gcall_o), .hw_gcall_o(hw_gcall_o),
    .hw_master_o(hw_master_o), .gc_illegal_o(gc_illegal_o), .gc_cmd_o(gc_cmd_o)
  );
endmodule

// File: tb/i2c_tgt_addr_rx_tb.sv
module i2c_tgt_addr_rx_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic [9:0] own_addr_i = '0;
  logic ten_bit_i = 1'b0, gc_en_i = 1'b0;
  logic dec_vld_o, ack_o, addressed_o, read_o, gcall_o, hw_gcall_o, gc_illegal_o;
  logic [6:0] hw_master_o;
  logic [1:0] gc_cmd_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tgt_addr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .own_addr_i(own_addr_i),
    .ten_bit_i(ten_bit_i), .gc_en_i(gc_en_i), .dec_vld_o(dec_vld_o), .ack_o(ack_o),
    .addressed_o(addressed_o), .read_o(read_o), .gcall_o(gcall_o),
    .hw_gcall_o(hw_gcall_o), .hw_master_o(hw_master_o),
    .gc_illegal_o(gc_illegal_o), .gc_cmd_o(gc_cmd_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
  endtask

  // drives one byte; returns at the negedge after the capturing edge
  task automatic send(logic [7:0] b);
    @(negedge clk) begin byte_i = b; byte_vld_i = 1'b1; end
    @(negedge clk) byte_vld_i = 1'b0;
  endtask

  task automatic dec(string req, int v, int a);
    chk(req, "dec_vld", int'(dec_vld_o), v);
    chk(req, "ack", int'(ack_o), a);
  endtask

  task automatic t_reset();
    chk("R10", "reset addressed", int'(addressed_o), 0);
    chk("R10", "reset gcall", int'(gcall_o), 0);
    chk("R1", "reset dec", int'(dec_vld_o), 0);
  endtask

  task automatic t_seven();
    ten_bit_i = 0; own_addr_i = 10'h02A;
    pulse_start(); send(8'h55);
    dec("R1", 1, 1); chk("R1", "addressed", int'(addressed_o), 1); chk("R1", "read", int'(read_o), 1);
    send(8'h54); dec("R11", 0, 0);
    chk("R11", "addressed kept", int'(addressed_o), 1);
    pulse_start(); chk("R10", "start clears", int'(addressed_o), 0);
    send(8'h54); dec("R1", 1, 1); chk("R1", "write dir", int'(read_o), 0);
    pulse_start(); send(8'h56); dec("R1", 1, 0); chk("R1", "miss addressed", int'(addressed_o), 0);
  endtask

  task automatic t_reserved();
    ten_bit_i = 0; own_addr_i = 10'h07C;
    pulse_start(); send(8'hF8); dec("R2", 1, 0); chk("R2", "7b 1111 addressed", int'(addressed_o), 0);
    own_addr_i = 10'h07A;
    pulse_start(); send(8'hF4); dec("R2", 1, 0);
    ten_bit_i = 1; own_addr_i = 10'h3C5;
    pulse_start(); send(8'hFE); dec("R2", 1, 0); chk("R2", "10b rsvd addressed", int'(addressed_o), 0);
    send(8'hC5); dec("R2", 0, 0);
  endtask

  task automatic t_ten();
    ten_bit_i = 1; own_addr_i = 10'h2C5;
    pulse_start(); send(8'hF4);
    dec("R3", 1, 1); chk("R3", "not yet addressed", int'(addressed_o), 0);
    send(8'hC5); dec("R3", 1, 1);
    chk("R3", "addressed", int'(addressed_o), 1); chk("R3", "read", int'(read_o), 0);
    pulse_start(); send(8'hF5); dec("R5", 1, 1);
    chk("R5", "addressed", int'(addressed_o), 1); chk("R5", "read", int'(read_o), 1);
    pulse_stop(); chk("R10", "stop clears", int'(addressed_o), 0);
    send(8'hF4); dec("R10", 0, 0);
    pulse_start(); send(8'hF5); dec("R5", 1, 0); chk("R5", "no reselect", int'(addressed_o), 0);
    pulse_start(); send(8'hF4); send(8'hC4); dec("R3", 1, 0);
    chk("R3", "low miss", int'(addressed_o), 0);
    pulse_start(); send(8'hF6); dec("R4", 1, 0);
  endtask

  task automatic t_prefix_on_seven();
    ten_bit_i = 0; own_addr_i = 10'h045;
    pulse_start(); send(8'hF4); dec("R4", 1, 0);
    send(8'h8A); dec("R4", 0, 0); chk("R4", "not addressed", int'(addressed_o), 0);
  endtask

  task automatic t_gc();
    gc_en_i = 0;
    pulse_start(); send(8'h00); dec("R6", 1, 0); chk("R6", "gcall off", int'(gcall_o), 0);
    gc_en_i = 1;
    pulse_start(); send(8'h00); dec("R6", 1, 1); chk("R6", "gcall", int'(gcall_o), 1);
    send(8'h8B); dec("R7", 1, 1);
    chk("R7", "hw", int'(hw_gcall_o), 1); chk("R7", "master", int'(hw_master_o), 'h45);
    pulse_start(); send(8'h00); send(8'h00); dec("R8", 1, 0);
    chk("R8", "illegal", int'(gc_illegal_o), 1);
    pulse_start(); send(8'h00); send(8'h06); dec("R9", 1, 1); chk("R9", "cmd rst", int'(gc_cmd_o), 1);
    pulse_start(); send(8'h00); send(8'h04); dec("R9", 1, 1); chk("R9", "cmd latch", int'(gc_cmd_o), 2);
    pulse_start(); send(8'h00); send(8'h0A); dec("R9", 1, 0);
    chk("R9", "no cmd", int'(gc_cmd_o), 0); chk("R9", "no ill", int'(gc_illegal_o), 0);
    chk("R9", "no hw", int'(hw_gcall_o), 0);
    pulse_stop(); chk("R10", "gcall cleared", int'(gcall_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seven();
    t_reserved();
    t_ten();
    t_prefix_on_seven();
    t_gc();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule